// File: doc/BRIEF.md
# Offset-Buffered Streaming Prefix Scan

This block computes a running prefix of a data stream, one element per clock, for an associative operator whose result takes several clocks to appear. The operator here is modular addition wrapped in an `OP_LAT`-stage pipeline. A naive running total would have to wait `OP_LAT` clocks between elements, because each element needs the previous result. The block avoids this stall. Each incoming element is combined with the partial result from `OFFSET` elements earlier, and that result has already left the operator pipeline because `OFFSET >= OP_LAT`. Each stored partial therefore holds the sum of one residue class of element positions modulo `OFFSET`.

Before an element leaves the block, a correction stage adds together the most recent `OFFSET` partials. This turns the residue-class sums into the true prefix. An inclusive result uses the window ending at the element itself. An exclusive result uses the window ending one element earlier, so the first exclusive output is the identity value, zero.

Streams are framed by a valid strobe and a last marker. The scan mode is taken from the first element of each stream. A control state machine has three states:
- `ST_IDLE`: waiting for a stream.
- `ST_FILL`: the first `OFFSET` elements, which are combined with the identity.
- `ST_STEADY`: later elements, which are combined with the stored partial.

It has four transitions:
- `T_START`: IDLE→FILL, or IDLE→STEADY when `OFFSET` is 1.
- `T_SINGLE`: a one-element stream, which stays in IDLE.
- `T_FILL_DONE`: FILL→STEADY.
- `T_END`: FILL or STEADY→IDLE, taken on the last element.

After the last input, the pipeline keeps advancing every clock, so the remaining results drain out with no extra input.

Top module: `oscan_top`

## Requirements
- R1: After reset, and while no element is presented, `out_valid` stays 0.
- R2: With `in_incl`=1 on a stream's first element, output j equals x0+…+xj modulo 2^DW.
- R3: With `in_incl`=0 on a stream's first element, output j equals x0+…+x(j-1) modulo 2^DW, and output 0 equals 0.
- R4: Each output appears exactly `OP_LAT`+1 clocks after its input is accepted:
  - outputs keep input order;
  - one output is produced per input;
  - `out_last` is 1 only on the output of the input marked `in_last`.
- R5: `in_incl` is sampled only on a stream's first element; its value on later elements of the same stream has no effect.
- R6: Streams shorter than or equal to `OFFSET` elements, including a single element, give correct results in both modes.
- R7: A new stream may start on the clock after the previous last element. It carries no state from the previous stream and uses its own mode.
- R8: Within a stream, `in_valid` is held high from the first element through the element marked `in_last` (input rule).
- R9: Sums wrap modulo 2^DW with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Element present this clock |
| in_data | input | DW | Element value |
| in_last | input | 1 | Final element of the stream |
| in_incl | input | 1 | Scan mode, read on first element: 1 inclusive, 0 exclusive |
| out_valid | output | 1 | Result present this clock |
| out_data | output | DW | Prefix result |
| out_last | output | 1 | Result belongs to the final element |

## Verification
A wrong history tap or a wrong position index shows up first on the element at position `OFFSET` or `OFFSET`+1. That is the first element whose operand comes from history instead of the identity, so its value is wrong `OP_LAT`+1 clocks after it enters. A correction window that reaches into the previous stream shows up on the first few outputs of a back-to-back stream. A mode bit carried on the wrong element flips the first exclusive output away from zero. A timing slip in the operator pipeline or the output register moves `out_valid` and `out_last` by a clock relative to the input plus `OP_LAT`+1. Directed streams cover lengths below, at and above `OFFSET`, mode changes inside a stream, back-to-back framing and wraparound. An independent running sum checks every output value and its arrival clock.

// File: rtl/oscan_pkg.sv
package oscan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STEADY = 2'd2
    } scan_state_e;

    localparam logic MODE_EXCL = 1'b0;
    localparam logic MODE_INCL = 1'b1;

endpackage

// File: rtl/oscan_ctrl.sv
module oscan_ctrl
    import oscan_pkg::*;
#(
    parameter int OFFSET = 4,
    parameter int IW     = $clog2(OFFSET + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic          in_incl,
    output logic [IW-1:0] tag_idx,
    output logic          tag_incl,
    output logic          use_hist,
    output logic          active
);

    localparam logic [IW-1:0] IDX_SAT = IW'(OFFSET);

    scan_state_e   state_q, state_d;
    logic [IW-1:0] cnt_q, cnt_d;
    logic          mode_q, mode_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= MODE_INCL;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            mode_q  <= mode_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        mode_d  = mode_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    mode_d = in_incl;
                    if (!in_last) begin                         // T_START
                        cnt_d   = IW'(1);
                        state_d = (OFFSET == 1) ? ST_STEADY : ST_FILL;
                    end                                          // else T_SINGLE
                end
            end
            ST_FILL: begin
                if (in_valid) begin
                    if (in_last) begin                          // T_END
                        cnt_d   = '0;
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + IW'(1);
                        if ((cnt_q + IW'(1)) == IDX_SAT) begin  // T_FILL_DONE
                            state_d = ST_STEADY;
                        end
                    end
                end
            end
            ST_STEADY: begin
                if (in_valid && in_last) begin                  // T_END
                    cnt_d   = '0;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        tag_idx  = cnt_q;
        tag_incl = mode_q;
        use_hist = 1'b0;
        active   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                tag_idx  = '0;
                tag_incl = in_incl;
                active   = 1'b0;
            end
            ST_FILL: begin
                tag_idx = cnt_q;
            end
            ST_STEADY: begin
                tag_idx  = IDX_SAT;
                use_hist = 1'b1;
            end
            default: begin
                active = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/oscan_oppipe.sv
module oscan_oppipe #(
    parameter int DW  = 16,
    parameter int IW  = 3,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic          in_incl,
    input  logic [IW-1:0] in_idx,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] in_operand,
    output logic          hd_valid,
    output logic          hd_last,
    output logic          hd_incl,
    output logic [IW-1:0] hd_idx,
    output logic [DW-1:0] hd_data
);

    logic [DW-1:0] d_q [1:LAT];
    logic [IW-1:0] i_q [1:LAT];
    logic [LAT:1]  v_q, l_q, m_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
            l_q <= '0;
            m_q <= '0;
            for (int k = 1; k <= LAT; k++) begin
                d_q[k] <= '0;
                i_q[k] <= '0;
            end
        end else begin
            v_q[1] <= in_valid;
            l_q[1] <= in_valid & in_last;
            m_q[1] <= in_incl;
            i_q[1] <= in_idx;
            d_q[1] <= in_data + in_operand;
            for (int k = 2; k <= LAT; k++) begin
                v_q[k] <= v_q[k-1];
                l_q[k] <= l_q[k-1];
                m_q[k] <= m_q[k-1];
                i_q[k] <= i_q[k-1];
                d_q[k] <= d_q[k-1];
            end
        end
    end

    assign hd_valid = v_q[LAT];
    assign hd_last  = l_q[LAT];
    assign hd_incl  = m_q[LAT];
    assign hd_idx   = i_q[LAT];
    assign hd_data  = d_q[LAT];

endmodule

// File: rtl/oscan_history.sv
module oscan_history #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         head,
    output logic [DEPTH:0][DW-1:0] win
);

    logic [DW-1:0] sr_q [1:DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 1; k <= DEPTH; k++) sr_q[k] <= '0;
        end else begin
            sr_q[1] <= head;
            for (int k = 2; k <= DEPTH; k++) sr_q[k] <= sr_q[k-1];
        end
    end

    assign win[0] = head;
    for (genvar g = 1; g <= DEPTH; g++) begin : g_tap
        assign win[g] = sr_q[g];
    end

endmodule

// File: rtl/oscan_fixup.sv
module oscan_fixup #(
    parameter int DW     = 16,
    parameter int OFFSET = 4,
    parameter int IW     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OFFSET:0][DW-1:0] win,
    input  logic                    hd_valid,
    input  logic                    hd_last,
    input  logic                    hd_incl,
    input  logic [IW-1:0]           hd_idx,
    output logic                    out_valid,
    output logic [DW-1:0]           out_data,
    output logic                    out_last
);

    logic [DW-1:0] corr;

    // Sum the OFFSET partials that cover every residue class; entries
    // older than the stream's first element are skipped via the index.
    always_comb begin
        corr = '0;
        for (int k = 0; k <= OFFSET; k++) begin
            if ((hd_incl ? (k < OFFSET) : (k >= 1)) && (int'(hd_idx) >= k)) begin
                corr = corr + win[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= hd_valid;
            out_last  <= hd_valid & hd_last;
            out_data  <= corr;
        end
    end

endmodule

// File: rtl/oscan_top.sv
module oscan_top #(
    parameter int DW     = 16,
    parameter int OFFSET = 4,
    parameter int OP_LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    input  logic          in_incl,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_last
);

    localparam int IW  = $clog2(OFFSET + 1);
    localparam int TAP = OFFSET - OP_LAT;

    if (OFFSET < OP_LAT) begin : g_cfg_err
        $error("OFFSET must be at least OP_LAT");
    end

    logic [IW-1:0]           tag_idx, hd_idx;
    logic                    tag_incl, use_hist, stream_active;
    logic                    hd_valid, hd_last, hd_incl;
    logic [DW-1:0]           hd_data, operand;
    logic [OFFSET:0][DW-1:0] win;

    oscan_ctrl #(.OFFSET(OFFSET), .IW(IW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_incl  (in_incl),
        .tag_idx  (tag_idx),
        .tag_incl (tag_incl),
        .use_hist (use_hist),
        .active   (stream_active)
    );

    // Operand: identity during fill, partial from OFFSET elements back after
    assign operand = use_hist ? win[TAP] : '0;

    oscan_oppipe #(.DW(DW), .IW(IW), .LAT(OP_LAT)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_incl    (tag_incl),
        .in_idx     (tag_idx),
        .in_data    (in_data),
        .in_operand (operand),
        .hd_valid   (hd_valid),
        .hd_last    (hd_last),
        .hd_incl    (hd_incl),
        .hd_idx     (hd_idx),
        .hd_data    (hd_data)
    );

    oscan_history #(.DW(DW), .DEPTH(OFFSET)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .head  (hd_data),
        .win   (win)
    );

    oscan_fixup #(.DW(DW), .OFFSET(OFFSET), .IW(IW)) u_fix (
        .clk       (clk),
        .rst_n     (rst_n),
        .win       (win),
        .hd_valid  (hd_valid),
        .hd_last   (hd_last),
        .hd_incl   (hd_incl),
        .hd_idx    (hd_idx),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: rtl/oscan_chk.sv
module oscan_chk #(
    parameter int DW     = 16,
    parameter int OP_LAT = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] in_data,
    input logic          in_last,
    input logic          in_incl,
    input logic          busy,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          out_last
);

    localparam int DL = OP_LAT + 1;

    logic                   first_q, mode_q;
    logic [DW-1:0]          acc_q;
    logic [DL-1:0]          dv, dl, df, di;
    logic [DL-1:0][DW-1:0]  de;
    logic                   mode_now;
    logic [DW-1:0]          base, expv;

    assign mode_now = first_q ? in_incl : mode_q;
    assign base     = first_q ? '0 : acc_q;
    assign expv     = mode_now ? (base + in_data) : base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            mode_q  <= 1'b1;
            acc_q   <= '0;
            dv <= '0; dl <= '0; df <= '0; di <= '0; de <= '0;
        end else begin
            if (in_valid) begin
                first_q <= in_last;
                mode_q  <= mode_now;
                acc_q   <= base + in_data;
            end
            dv <= {dv[DL-2:0], in_valid};
            dl <= {dl[DL-2:0], in_valid & in_last};
            df <= {df[DL-2:0], first_q};
            di <= {di[DL-2:0], mode_now};
            de <= {de[DL-2:0], expv};
        end
    end

    AST_STREAM_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> in_valid); // R8
    AST_OUTPUT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == dv[DL-1]); // R4
    AST_LAST_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == dl[DL-1])); // R4
    AST_EXCL_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && df[DL-1] && !di[DL-1]) |-> (out_data == '0)); // R3
    AST_PREFIX_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == de[DL-1])); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dv[DL-1]) |-> !out_valid); // R1

endmodule

bind oscan_top oscan_chk #(.DW(DW), .OP_LAT(OP_LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_incl   (in_incl),
    .busy      (stream_active),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/oscan_top_tb.sv
`timescale 1ns/1ps
module oscan_top_tb;

    localparam int DW     = 16;
    localparam int OFFSET = 4;
    localparam int OP_LAT = 3;
    localparam int MAXN   = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic          in_incl = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_last;

    always #2 clk = ~clk;   // 250 MHz

    oscan_top #(.DW(DW), .OFFSET(OFFSET), .OP_LAT(OP_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_incl(in_incl),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    logic [DW-1:0] exp_d [0:MAXN-1];
    int            exp_c [0:MAXN-1];
    bit            exp_l [0:MAXN-1];
    string         exp_r [0:MAXN-1];
    int            n_exp = 0;
    logic [DW-1:0] obs_d [0:MAXN-1];
    int            obs_c [0:MAXN-1];
    bit            obs_l [0:MAXN-1];
    int            n_obs = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (out_valid && n_obs < MAXN) begin
            obs_d[n_obs] = out_data;
            obs_c[n_obs] = cyc;
            obs_l[n_obs] = out_last;
            n_obs = n_obs + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int kind, input int j);
        case (kind)
            0:       pat = DW'(j + 1);
            1:       pat = DW'(32'hF000 + j * 32'h0731);
            default: pat = DW'(((j * 37 + 11) * 13) ^ 32'h5A5A);
        endcase
    endfunction

    // Drives a gapless stream (input rule R8); no idle after the last element.
    task automatic send(input int len, input bit incl, input int kind,
                        input bit flip, input string rq);
        logic [DW-1:0] acc = '0;
        for (int j = 0; j < len; j++) begin
            logic [DW-1:0] d = pat(kind, j);
            exp_d[n_exp] = incl ? DW'(acc + d) : acc;
            exp_l[n_exp] = (j == len - 1);
            exp_r[n_exp] = rq;
            exp_c[n_exp] = cyc;
            n_exp++;
            acc      = acc + d;
            in_valid = 1'b1;
            in_data  = d;
            in_last  = (j == len - 1);
            in_incl  = (j == 0) ? incl : (flip ? ~incl : incl);
            @(negedge clk);
        end
    endtask

    task automatic drain_and_check();
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = '0;
        repeat (OP_LAT + 6) @(negedge clk);
        chk(n_obs == n_exp, "R4", "output count", n_obs, n_exp);
        for (int i = 0; i < n_exp && i < n_obs; i++) begin
            chk(obs_d[i] == exp_d[i], exp_r[i], $sformatf("value #%0d", i),
                int'(obs_d[i]), int'(exp_d[i]));
            chk(obs_c[i] - exp_c[i] == OP_LAT + 1, "R4", $sformatf("latency #%0d", i),
                obs_c[i] - exp_c[i], OP_LAT + 1);
            chk(obs_l[i] == exp_l[i], "R4", $sformatf("last mark #%0d", i),
                int'(obs_l[i]), int'(exp_l[i]));
        end
        n_exp = 0;
        n_obs = 0;
    endtask

    task automatic t_reset_quiet();
        for (int i = 0; i < 6; i++) begin
            chk(out_valid == 1'b0, "R1", "out_valid idle", int'(out_valid), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_inclusive_long();
        send(20, 1'b1, 0, 1'b0, "R2");
        drain_and_check();
    endtask

    task automatic t_exclusive_long();
        send(20, 1'b0, 2, 1'b0, "R3");
        in_valid = 1'b0;
        repeat (OP_LAT + 6) @(negedge clk);
        chk(n_obs > 0 && obs_d[0] == '0, "R3", "exclusive first identity",
            int'(obs_d[0]), 0);
        n_exp = 0; n_obs = 0;
        send(20, 1'b0, 2, 1'b0, "R3");
        drain_and_check();
    endtask

    task automatic t_short_streams();
        for (int len = 1; len <= OFFSET + 1; len++) begin
            send(len, 1'b1, 2, 1'b0, "R6");
            drain_and_check();
            send(len, 1'b0, 0, 1'b0, "R6");
            drain_and_check();
        end
    endtask

    task automatic t_mode_flip();
        send(12, 1'b1, 2, 1'b1, "R5");
        drain_and_check();
        send(12, 1'b0, 0, 1'b1, "R5");
        drain_and_check();
    endtask

    task automatic t_back_to_back();
        send(6, 1'b1, 2, 1'b0, "R7");
        send(9, 1'b0, 0, 1'b0, "R7");
        send(1, 1'b1, 1, 1'b0, "R7");
        send(3, 1'b0, 1, 1'b0, "R7");
        drain_and_check();
    endtask

    task automatic t_wraparound();
        send(15, 1'b1, 1, 1'b0, "R9");
        drain_and_check();
        send(15, 1'b0, 1, 1'b0, "R9");
        drain_and_check();
    endtask

    bit done = 1'b0;

    always @(posedge clk) begin
        if (!done && cyc > 50000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 50000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_quiet();
        t_inclusive_long();
        t_exclusive_long();
        t_short_streams();
        t_mode_flip();
        t_back_to_back();
        t_wraparound();
        t_reset_quiet();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule